// File: doc/BRIEF.md
# Video Memory Time-Slot Arbiter

This block shares one video memory port between the display refresh fetcher and the host bus. Time is cut into a frame of five memory cycles that repeats without a break. Within each frame, the leading slots belong to the display path and the remaining slots belong to the host. A single split-select input chooses between two divisions of the frame. One division gives four display slots and one host slot, which suits 640-pixel-wide timings. The other gives two display slots and three host slots, which suits 320-pixel-wide timings. When the display path produces 16 pixels per fetch, the slower division becomes usable at the wider timing.

Each cycle, the block reports the current slot number, which side owns the slot, and whether a new frame is starting. It raises a fetch strobe when the display path owns the slot and wants data. A display slot stays reserved even when no fetch is wanted, for example during blanking, so the slot timing never depends on the picture content. The host holds a request until it is acknowledged. The acknowledge is given only in a host-owned slot. While the host waits for such a slot, the block raises a stall indication.

Top module: `vmem_slot_arbiter`

## Requirements
- R1: While reset is asserted, the slot index is 0, the owner is display (slot_owner = 0), and disp_fetch and host_ack are both low whatever the inputs. The first frame after reset uses the four-display split.
- R2: After reset is released, slot_idx advances by one on every clock and returns from 4 to 0. frame_start is high exactly when slot_idx is 0.
- R3: With the four-display split active (split value 0), slots 0 to 3 are owned by display (slot_owner = 0) and slot 4 is owned by the host (slot_owner = 1).
- R4: With the three-host split active (split value 1), slots 0 and 1 are owned by display and slots 2, 3 and 4 are owned by the host.
- R5: split_sel is sampled only on the clock edge that leaves slot 4, and the sampled value governs the whole of the next frame. Changes of split_sel at any other time have no effect on slot ownership until then.
- R6: disp_fetch is high exactly when the slot is display-owned and disp_need is high. A display slot with disp_need low stays display-owned and gives no acknowledge to a waiting host.
- R7: host_ack is high exactly when the slot is host-owned and host_req is high. This completes one host access per host slot. host_wait is high when host_req is high and host_ack is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_sel | input | 1 | 0 = four display / one host, 1 = two display / three host |
| disp_need | input | 1 | Display path wants a fetch (low during blanking) |
| host_req | input | 1 | Host access request, held until acknowledged |
| slot_idx | output | 3 | Position of the current slot within the frame |
| slot_owner | output | 1 | 0 = display owns the slot, 1 = host owns it |
| frame_start | output | 1 | High in slot 0 |
| disp_fetch | output | 1 | Display fetch strobe for this slot |
| host_ack | output | 1 | Host access completes in this slot |
| host_wait | output | 1 | Host is stalled waiting for a host slot |

## Verification
The bench first sweeps all four combinations of disp_need and host_req under each split, holding each combination for whole frames. This separates the ownership map from the request gating and shows that a blanked display slot still refuses the host. A pseudo-random phase then flips split_sel at arbitrary slot positions, including mid-frame and on slot 4 itself. A slot counter computed in the bench predicts the frame in which each flip must take effect, which exposes any sampling on the wrong edge. A final reset pulse in the middle of a frame checks the return to slot 0 and to the four-display split.

// File: rtl/vmsa_pkg.sv
package vmsa_pkg;

    typedef enum logic {
        OWN_DISP = 1'b0,
        OWN_HOST = 1'b1
    } owner_e;

    typedef enum logic {
        SPLIT_DISP_HEAVY = 1'b0,
        SPLIT_HOST_HEAVY = 1'b1
    } split_e;

endpackage

// File: rtl/vmsa_frame_seq.sv
module vmsa_frame_seq #(
    parameter int FRAME_LEN = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         split_sel,
    output logic [$clog2(FRAME_LEN)-1:0] slot_idx,
    output vmsa_pkg::split_e             split_act,
    output logic                         frame_start
);
    import vmsa_pkg::*;

    localparam int SW = $clog2(FRAME_LEN);
    localparam logic [SW-1:0] LAST_SLOT = SW'(FRAME_LEN - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
        split_e        split;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST_SLOT) begin
            st_d.slot  = '0;
            st_d.split = split_e'(split_sel);
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot  <= '0;
            st_q.split <= SPLIT_DISP_HEAVY;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_idx    = st_q.slot;
    assign split_act   = st_q.split;
    assign frame_start = (st_q.slot == '0);

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == LAST_SLOT) |=> (slot_idx == '0));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != LAST_SLOT) |=> (slot_idx == $past(slot_idx) + 1'b1));

    // R5
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != LAST_SLOT) |=> $stable(split_act));

    // R5
    split_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == LAST_SLOT) |=> (split_act == split_e'($past(split_sel))));

endmodule

// File: rtl/vmsa_owner_map.sv
module vmsa_owner_map #(
    parameter int FRAME_LEN = 5,
    parameter int HI_DISP   = 4,
    parameter int LO_DISP   = 2
) (
    input  logic [$clog2(FRAME_LEN)-1:0] slot_idx,
    input  vmsa_pkg::split_e             split_act,
    output vmsa_pkg::owner_e             owner
);
    import vmsa_pkg::*;

    logic [FRAME_LEN-1:0] host_map_hi;
    logic [FRAME_LEN-1:0] host_map_lo;

    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_map
        assign host_map_hi[i] = (i >= HI_DISP);
        assign host_map_lo[i] = (i >= LO_DISP);
    end

    always_comb begin
        if (split_act == SPLIT_HOST_HEAVY)
            owner = owner_e'(host_map_lo[slot_idx]);
        else
            owner = owner_e'(host_map_hi[slot_idx]);
    end

endmodule

// File: rtl/vmsa_port_gate.sv
module vmsa_port_gate (
    input  logic             clk,
    input  logic             rst_n,
    input  vmsa_pkg::owner_e owner,
    input  logic             disp_need,
    input  logic             host_req,
    output logic             disp_fetch,
    output logic             host_ack,
    output logic             host_wait
);
    import vmsa_pkg::*;

    always_comb begin
        disp_fetch = rst_n && (owner == OWN_DISP) && disp_need;
        host_ack   = rst_n && (owner == OWN_HOST) && host_req;
        host_wait  = host_req && !host_ack;
    end

    // R7
    ack_in_host_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (owner == OWN_HOST));

    // R6
    fetch_in_disp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fetch |-> (owner == OWN_DISP));

    // R6
    one_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_fetch, host_ack}));

endmodule

// File: rtl/vmem_slot_arbiter.sv
module vmem_slot_arbiter #(
    parameter int FRAME_LEN = 5,
    parameter int HI_DISP   = 4,
    parameter int LO_DISP   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         split_sel,
    input  logic                         disp_need,
    input  logic                         host_req,
    output logic [$clog2(FRAME_LEN)-1:0] slot_idx,
    output logic                         slot_owner,
    output logic                         frame_start,
    output logic                         disp_fetch,
    output logic                         host_ack,
    output logic                         host_wait
);
    import vmsa_pkg::*;

    localparam int SW = $clog2(FRAME_LEN);

    split_e split_act;
    owner_e owner;

    vmsa_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_sel  (split_sel),
        .slot_idx   (slot_idx),
        .split_act  (split_act),
        .frame_start(frame_start)
    );

    vmsa_owner_map #(
        .FRAME_LEN(FRAME_LEN),
        .HI_DISP  (HI_DISP),
        .LO_DISP  (LO_DISP)
    ) u_map (
        .slot_idx (slot_idx),
        .split_act(split_act),
        .owner    (owner)
    );

    vmsa_port_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner     (owner),
        .disp_need (disp_need),
        .host_req  (host_req),
        .disp_fetch(disp_fetch),
        .host_ack  (host_ack),
        .host_wait (host_wait)
    );

    assign slot_owner = owner;

    // Host acknowledges seen so far in the current frame.
    logic [SW:0] acks_q, acks_d;

    always_comb begin
        acks_d = frame_start ? '0 : acks_q;
        if (host_ack) acks_d = acks_d + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acks_q <= '0;
        else        acks_q <= acks_d;
    end

    // R3
    frame_opens_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (owner == OWN_DISP));

    // R7
    ack_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !frame_start) |->
            (int'(acks_q) < ((split_act == SPLIT_HOST_HEAVY) ? (FRAME_LEN - LO_DISP)
                                                             : (FRAME_LEN - HI_DISP))));

endmodule

// File: tb/tb_vmem_slot_arbiter.sv
module tb_vmem_slot_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       split_sel, disp_need, host_req;
    logic [2:0] slot_idx;
    logic       slot_owner, frame_start, disp_fetch, host_ack, host_wait;

    int errors = 0;
    int checks = 0;
    int mslot  = 0;
    bit msplit = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    vmem_slot_arbiter dut (
        .clk(clk), .rst_n(rst_n), .split_sel(split_sel), .disp_need(disp_need),
        .host_req(host_req), .slot_idx(slot_idx), .slot_owner(slot_owner),
        .frame_start(frame_start), .disp_fetch(disp_fetch), .host_ack(host_ack),
        .host_wait(host_wait)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (slot %0d)", tag, act, exp, mslot);
        end
    endtask

    // Advance the bench's own frame model on a clock edge.
    task automatic edge_step();
        @(posedge clk);
        if (!rst_n) begin
            mslot  = 0;
            msplit = 0;
        end else if (mslot == 4) begin
            mslot  = 0;
            msplit = split_sel;
        end else begin
            mslot++;
        end
        #2;
    endtask

    task automatic check_all();
        bit own;
        #1;
        own = msplit ? (mslot >= 2) : (mslot >= 4);
        chk("R2 slot_idx", slot_idx, mslot);
        chk("R2 frame_start", frame_start, mslot == 0);
        chk(msplit ? "R4 R5 owner" : "R3 R5 owner", slot_owner, own);
        chk("R6 disp_fetch", disp_fetch, !own && disp_need);
        chk("R7 host_ack", host_ack, own && host_req);
        chk("R7 host_wait", host_wait, host_req && !(own && host_req));
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; split_sel = 1'b1; disp_need = 1'b1; host_req = 1'b1;
        repeat (3) edge_step();
        #1;
        // R1: reset state with all requests asserted
        chk("R1 slot_idx", slot_idx, 0);
        chk("R1 owner", slot_owner, 0);
        chk("R1 disp_fetch", disp_fetch, 0);
        chk("R1 host_ack", host_ack, 0);
        rst_n = 1'b1;
        // split_sel=1 during reset must not apply to the first frame (R1)
        check_all();

        // Deterministic sweep: each split, each need/req pattern, two frames each
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int c = 0; c < 10; c++) begin
                    edge_step();
                    split_sel = s[0];
                    disp_need = p[0];
                    host_req  = p[1];
                    check_all();
                end
            end
        end

        // Pseudo-random phase: split flips at arbitrary slot positions
        for (int c = 0; c < 600; c++) begin
            edge_step();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:5] == 3'd0) split_sel = ~split_sel;
            disp_need = lfsr[1];
            host_req  = lfsr[3] | lfsr[9];
            check_all();
        end

        // Mid-frame reset returns to slot 0 and the four-display split (R1)
        split_sel = 1'b1;
        rst_n = 1'b0;
        edge_step();
        #1;
        chk("R1 slot after reset", slot_idx, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 12; c++) begin
            edge_step();
            check_all();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule